// File: doc/BRIEF.md
# Parity-Checked Bridge Data Queues with Poisoning

This block is the data path of a bridge. A narrow inbound link feeds four outbound queues: PCI posted writes, AGP low-priority read returns, AGP high-priority read returns and PCI read returns. Traffic on the link is a sequence of packets. Each packet starts with a header beat, and a number of data beats follows it. Every beat is 19 bits wide: 16 data bits, 2 byte-enable bits and one parity bit. Parity is even and covers both the data and the byte enables.

The first beat after reset, and the first beat after each complete packet, is taken as a header. Header bits [1:0] select the target queue (0 = PCI write, 1 = AGP low, 2 = AGP high, 3 = PCI return). Header bits [5:2] give the number of data beats that follow. The block stores each beat with the parity it arrived with, and checks parity again when the beat leaves its queue. A header that fails parity discards its whole packet and raises a bus-initialization error. A PCI-bound data beat that fails parity is still kept, with its parity forced bad, so the error travels on to the consumer.

A sticky error-status register records every kind of error, and a capture register holds the beat behind the first error. Software clears status bits by writing ones to them.

Top module: `bridge_parity_queue`

## Requirements
- R1: A data beat with good parity comes out of its target port unchanged in data, byte enables and parity. Even parity means that the XOR of par, be[1:0] and data[15:0] is 0. Class 0 drains on the pciw port, classes 1 and 2 drain on the agp port, and class 3 drains on the pcir port.
- R2: A header with bad parity sets err_status bit 0. It also drives bus_init_err high during the cycle after the header is accepted, and low again one cycle later.
- R3: After a bad header, the number of beats given in its length field is accepted with in_ready high and discarded. The beat after them is decoded as a new header, and no discarded beat reaches any output.
- R4: A data beat with bad parity sets err_status bit 1. When its class is 0 or 3, the beat is queued with parity set to the inverse of the even parity of its data and byte enables, and it is delivered with that failing parity.
- R5: A data beat with bad parity whose class is 1 or 2 is queued with its parity bit exactly as it was received.
- R6: Parity is checked when an entry leaves queue q. A failing entry sets err_status bit 2+q in the cycle after the pop.
- R7: A PCI return (class 3) beat that arrived with bad parity leaves the pcir port with failing parity and sets err_status bits 1 and 5.
- R8: When an inbound data error and a readout error occur in the same cycle, both status bits are set.
- R9: Status bits stay set until a one is written to the matching bit of err_clr. Clearing one bit leaves the other bits unchanged.
- R10: err_capture loads {par, be, data} of the failing beat only when err_status was all zeros before that cycle. Later errors do not overwrite it.
- R11: Each queue holds 8 entries. While the target queue of a data beat is full, in_ready stays low and the beat waits. The beat is accepted once an entry has been popped.
- R12: When both AGP queues hold data, the agp port serves the high-priority queue first and shows agp_hi = 1 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound beat present |
| in_ready | output | 1 | Inbound beat accepted this cycle |
| in_data | input | 16 | Inbound data or header bits |
| in_be | input | 2 | Inbound byte enables |
| in_par | input | 1 | Inbound even parity bit |
| bus_init_err | output | 1 | Pulse after a header parity failure |
| pciw_valid | output | 1 | PCI write queue head valid |
| pciw_ready | input | 1 | PCI write consumer takes the head |
| pciw_data | output | 16 | PCI write data |
| pciw_be | output | 2 | PCI write byte enables |
| pciw_par | output | 1 | PCI write stored parity |
| agp_valid | output | 1 | An AGP queue has data |
| agp_ready | input | 1 | AGP consumer takes the head |
| agp_hi | output | 1 | Head comes from the high-priority queue |
| agp_data | output | 16 | AGP data |
| agp_be | output | 2 | AGP byte enables |
| agp_par | output | 1 | AGP stored parity |
| pcir_valid | output | 1 | PCI return queue head valid |
| pcir_ready | input | 1 | PCI return consumer takes the head |
| pcir_data | output | 16 | PCI return data |
| pcir_be | output | 2 | PCI return byte enables |
| pcir_par | output | 1 | PCI return parity, poisoned when bad |
| err_clr | input | 6 | Write-one-to-clear mask for err_status |
| err_status | output | 6 | Sticky error bits: 0 header, 1 inbound data, 2..5 readout of queue 0..3 |
| err_capture | output | 19 | {par, be, data} of the first error's beat |

## Verification
A data beat accepted at one clock edge appears at the head of its port right after that edge. The bench therefore checks port contents at the next falling edge, before it raises the matching ready. Inbound errors, header errors and the bus_init_err pulse are registered at the edge that accepts the beat. Readout errors are registered at the edge of the pop. Each of these is sampled at the falling edge that follows. Reset release is delayed by two internal synchronizer flops, and the bench waits past them before its first check.

// File: rtl/bpq_pkg.sv
package bpq_pkg;
  localparam int DATA_W  = 16;
  localparam int BE_W    = 2;
  localparam int ENTRY_W = DATA_W + BE_W + 1;
  localparam int NUM_Q   = 4;
  localparam int ERR_W   = NUM_Q + 2;

  typedef logic [ENTRY_W-1:0] entry_t;

  typedef enum logic [1:0] {
    CLS_PCIW = 2'd0,
    CLS_AGPL = 2'd1,
    CLS_AGPH = 2'd2,
    CLS_PCIR = 2'd3
  } qcls_e;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_DROP = 2'd2
  } rx_st_e;
endpackage

// File: rtl/bpq_fifo.sv
module bpq_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_d  = push ? adv(wp_q) : wp_q;
    rp_d  = pop  ? adv(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> !push || pop);
  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop);
endmodule

// File: rtl/bpq_inbound.sv
module bpq_inbound
  import bpq_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [BE_W-1:0]    in_be,
  input  logic               in_par,
  input  logic [NUM_Q-1:0]   q_full,
  output logic [NUM_Q-1:0]   push,
  output entry_t             wentry,
  output entry_t             rx_entry,
  output logic               hdr_err,
  output logic               dat_err,
  output logic               bini
);
  rx_st_e           st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       cls_q, cls_d;
  logic             bini_q;
  logic             acc, par_ok, to_pci;
  logic [LEN_W-1:0] hlen;

  assign par_ok   = ~^{in_par, in_be, in_data};
  assign hlen     = in_data[2 +: LEN_W];
  assign in_ready = (st_q == ST_DATA) ? !q_full[cls_q] : 1'b1;
  assign acc      = in_valid && in_ready;
  assign to_pci   = (cls_q == CLS_PCIW) || (cls_q == CLS_PCIR);
  assign rx_entry = {in_par, in_be, in_data};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cls_d   = cls_q;
    push    = '0;
    hdr_err = 1'b0;
    dat_err = 1'b0;
    wentry  = rx_entry;
    if (acc) begin
      unique case (st_q)
        ST_HDR: begin
          cnt_d = hlen;
          cls_d = in_data[1:0];
          if (!par_ok) begin
            hdr_err = 1'b1;
            if (hlen != '0) st_d = ST_DROP;
          end else if (hlen != '0) begin
            st_d = ST_DATA;
          end
        end
        ST_DATA, ST_DROP: begin
          cnt_d = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) st_d = ST_HDR;
          if (st_q == ST_DATA) begin
            push[cls_q] = 1'b1;
            dat_err     = !par_ok;
            if (!par_ok && to_pci) wentry = {~^{in_be, in_data}, in_be, in_data};
          end
        end
        default: st_d = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      cnt_q  <= '0;
      cls_q  <= '0;
      bini_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      cls_q  <= cls_d;
      bini_q <= hdr_err;
    end
  end

  assign bini = bini_q;

  // R3
  drop_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_DROP) |-> (push == '0));
  // R11
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n) (push & q_full) == '0);
endmodule

// File: rtl/bpq_errlog.sv
module bpq_errlog
  import bpq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set,
  input  logic [ERR_W-1:0] clr,
  input  entry_t           cap_in,
  output logic [ERR_W-1:0] status,
  output entry_t           cap
);
  logic [ERR_W-1:0] st_q, st_d;
  entry_t           cap_q, cap_d;
  logic             cap_en;

  assign cap_en = (st_q == '0) && (set != '0);

  always_comb begin
    st_d  = (st_q & ~clr) | set;
    cap_d = cap_en ? cap_in : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cap_q <= '0;
    end else begin
      st_q  <= st_d;
      cap_q <= cap_d;
    end
  end

  assign status = st_q;
  assign cap    = cap_q;

  for (genvar i = 0; i < ERR_W; i++) begin : g_sticky
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_q[i] && !clr[i]) |=> st_q[i]);
  end
  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (st_q != '0) |=> $stable(cap_q));
endmodule

// File: rtl/bridge_parity_queue.sv
module bridge_parity_queue
  import bpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  input  logic              in_par,
  output logic              bus_init_err,
  output logic              pciw_valid,
  input  logic              pciw_ready,
  output logic [DATA_W-1:0] pciw_data,
  output logic [BE_W-1:0]   pciw_be,
  output logic              pciw_par,
  output logic              agp_valid,
  input  logic              agp_ready,
  output logic              agp_hi,
  output logic [DATA_W-1:0] agp_data,
  output logic [BE_W-1:0]   agp_be,
  output logic              agp_par,
  output logic              pcir_valid,
  input  logic              pcir_ready,
  output logic [DATA_W-1:0] pcir_data,
  output logic [BE_W-1:0]   pcir_be,
  output logic              pcir_par,
  input  logic [ERR_W-1:0]  err_clr,
  output logic [ERR_W-1:0]  err_status,
  output logic [ENTRY_W-1:0] err_capture
);
  logic [1:0]       rs_q;
  logic             rst_i;
  logic [NUM_Q-1:0] push, pop, q_full, q_empty, rd_err;
  entry_t           head [NUM_Q];
  entry_t           wentry, rx_entry, cap_in, agp_e;
  logic             hdr_err, dat_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  bpq_inbound #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_i), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_be(in_be), .in_par(in_par), .q_full(q_full),
    .push(push), .wentry(wentry), .rx_entry(rx_entry), .hdr_err(hdr_err),
    .dat_err(dat_err), .bini(bus_init_err)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    bpq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_i), .push(push[q]), .wdata(wentry), .pop(pop[q]),
      .rdata(head[q]), .empty(q_empty[q]), .full(q_full[q])
    );
    assign rd_err[q] = pop[q] && (^head[q]);
  end

  // output side: AGP high-priority queue wins over the low one
  assign agp_hi     = !q_empty[CLS_AGPH];
  assign agp_valid  = !q_empty[CLS_AGPH] || !q_empty[CLS_AGPL];
  assign agp_e      = agp_hi ? head[CLS_AGPH] : head[CLS_AGPL];
  assign pciw_valid = !q_empty[CLS_PCIW];
  assign pcir_valid = !q_empty[CLS_PCIR];

  assign pop[CLS_PCIW] = pciw_valid && pciw_ready;
  assign pop[CLS_AGPH] = agp_valid && agp_ready && agp_hi;
  assign pop[CLS_AGPL] = agp_valid && agp_ready && !agp_hi;
  assign pop[CLS_PCIR] = pcir_valid && pcir_ready;

  assign {pciw_par, pciw_be, pciw_data} = head[CLS_PCIW];
  assign {agp_par, agp_be, agp_data}    = agp_e;
  assign {pcir_par, pcir_be, pcir_data} = head[CLS_PCIR];

  always_comb begin
    cap_in = rx_entry;
    if (!hdr_err && !dat_err) begin
      for (int q = NUM_Q - 1; q >= 0; q--) begin
        if (rd_err[q]) cap_in = head[q];
      end
    end
  end

  bpq_errlog u_err (
    .clk(clk), .rst_n(rst_i), .set({rd_err, dat_err, hdr_err}), .clr(err_clr),
    .cap_in(cap_in), .status(err_status), .cap(err_capture)
  );

  // R2
  bini_flag_chk: assert property (@(posedge clk) disable iff (!rst_i) bus_init_err |-> err_status[0]);
  // R6
  pcir_rd_err_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pcir_valid && pcir_ready && (^{pcir_par, pcir_be, pcir_data})) |=> err_status[5]);
  // R12
  agp_prio_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (agp_valid && agp_ready && !agp_hi) |-> q_empty[CLS_AGPH]);
endmodule

// File: tb/sim_bridge_parity_queue.sv
`timescale 1ns/1ps
module sim_bridge_parity_queue;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_par, bus_init_err;
  logic [15:0] in_data;
  logic [1:0]  in_be;
  logic pciw_valid, pciw_ready, pciw_par;
  logic [15:0] pciw_data;
  logic [1:0]  pciw_be;
  logic agp_valid, agp_ready, agp_hi, agp_par;
  logic [15:0] agp_data;
  logic [1:0]  agp_be;
  logic pcir_valid, pcir_ready, pcir_par;
  logic [15:0] pcir_data;
  logic [1:0]  pcir_be;
  logic [5:0]  err_clr, err_status;
  logic [18:0] err_capture;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bridge_parity_queue u0 (.*);

  // vector: cls[26:25] bad[24] be[23:22] data[21:6] expected status[5:0]
  localparam logic [26:0] VEC [8] = '{
    {2'd0, 1'b0, 2'd3, 16'hA5C3, 6'b000000},
    {2'd1, 1'b0, 2'd1, 16'h1234, 6'b000000},
    {2'd2, 1'b0, 2'd2, 16'hFFFF, 6'b000000},
    {2'd3, 1'b0, 2'd3, 16'h0F0F, 6'b000000},
    {2'd0, 1'b1, 2'd3, 16'h5555, 6'b000110},
    {2'd1, 1'b1, 2'd2, 16'h3C01, 6'b001010},
    {2'd2, 1'b1, 2'd0, 16'h8001, 6'b010010},
    {2'd3, 1'b1, 2'd1, 16'h7E7E, 6'b100010}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [18:0] ent(input logic [15:0] d, input logic [1:0] be, input logic bad);
    return {(^{be, d}) ^ bad, be, d};
  endfunction

  task automatic do_reset();
    in_valid = 0; in_data = '0; in_be = '0; in_par = 0;
    pciw_ready = 0; agp_ready = 0; pcir_ready = 0; err_clr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_beat(input logic [15:0] d, input logic [1:0] be, input logic bad);
    @(negedge clk);
    in_valid = 1; {in_par, in_be, in_data} = ent(d, be, bad);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_hdr(input logic [1:0] cls, input logic [3:0] len, input logic bad);
    send_beat({10'd0, len, cls}, 2'b11, bad);
  endtask

  task automatic set_ready(input int port, input logic v);
    case (port)
      0: pciw_ready = v;
      1: agp_ready = v;
      default: pcir_ready = v;
    endcase
  endtask

  // called at a falling edge; checks the head, then pops it
  task automatic pop_chk(input string r, input int port, input logic [18:0] exp_e, input logic exp_hi);
    logic v; logic [18:0] e;
    case (port)
      0: begin v = pciw_valid; e = {pciw_par, pciw_be, pciw_data}; end
      1: begin v = agp_valid;  e = {agp_par, agp_be, agp_data}; end
      default: begin v = pcir_valid; e = {pcir_par, pcir_be, pcir_data}; end
    endcase
    chk({r, " valid"}, 32'(v), 32'd1);
    chk({r, " entry"}, 32'(e), 32'(exp_e));
    if (port == 1) chk({r, " agp_hi"}, 32'(agp_hi), 32'(exp_hi));
    set_ready(port, 1'b1);
    @(negedge clk);
    set_ready(port, 1'b0);
  endtask

  task automatic clear_all();
    @(negedge clk); err_clr = '1;
    @(negedge clk); err_clr = '0;
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    chk("reset in_ready", 32'(in_ready), 32'd1);
    chk("reset valids", 32'({pciw_valid, agp_valid, pcir_valid}), 32'd0);
    chk("reset status", 32'(err_status), 32'd0);
    chk("reset capture", 32'(err_capture), 32'd0);
    chk("reset bini", 32'(bus_init_err), 32'd0);

    // R1 R4 R5 R6 R7: table of single-beat packets
    foreach (VEC[i]) begin
      logic [1:0] c; logic b; logic [1:0] be; logic [15:0] d; logic [5:0] xs; int port;
      {c, b, be, d, xs} = VEC[i];
      port = (c == 2'd0) ? 0 : (c == 2'd3) ? 2 : 1;
      clear_all();
      send_hdr(c, 4'd1, 1'b0);
      send_beat(d, be, b);
      chk(b ? "R4 R5 inbound flag" : "R1 no flag", 32'(err_status[1]), 32'(b));
      pop_chk(b ? "R4 R5 R7 bad beat" : "R1 good beat", port, ent(d, be, b), c == 2'd2);
      chk("R6 R7 status after pop", 32'(err_status), 32'(xs));
    end

    // R2 R3: bad header drops its data beats
    do_reset();
    send_hdr(2'd0, 4'd2, 1'b1);
    chk("R2 bini high", 32'(bus_init_err), 32'd1);
    chk("R2 status", 32'(err_status), 32'd1);
    @(negedge clk);
    chk("R2 bini one cycle", 32'(bus_init_err), 32'd0);
    send_beat(16'hDEAD, 2'b11, 1'b0);
    send_beat(16'hBEEF, 2'b01, 1'b0);
    chk("R3 dropped beats absent", 32'({pciw_valid, agp_valid, pcir_valid}), 32'd0);
    send_hdr(2'd0, 4'd1, 1'b0);
    send_beat(16'h4321, 2'b10, 1'b0);
    pop_chk("R3 next header decoded", 0, ent(16'h4321, 2'b10, 1'b0), 1'b0);
    chk("R3 queue empty", 32'(pciw_valid), 32'd0);

    // R9: partial clear
    send_hdr(2'd1, 4'd1, 1'b0);
    send_beat(16'h0001, 2'b11, 1'b1);
    chk("R9 two bits", 32'(err_status), 32'h3);
    @(negedge clk); err_clr = 6'b000001;
    @(negedge clk); err_clr = '0;
    chk("R9 partial clear", 32'(err_status), 32'h2);
    @(negedge clk);
    chk("R9 sticky", 32'(err_status), 32'h2);

    // R10: capture only the first error
    do_reset();
    send_hdr(2'd1, 4'd2, 1'b0);
    send_beat(16'h00F1, 2'b11, 1'b1);
    send_beat(16'h0F02, 2'b01, 1'b1);
    chk("R10 first captured", 32'(err_capture), 32'(ent(16'h00F1, 2'b11, 1'b1)));
    clear_all();
    send_hdr(2'd1, 4'd1, 1'b0);
    send_beat(16'hC0DE, 2'b10, 1'b1);
    chk("R10 reload after clear", 32'(err_capture), 32'(ent(16'hC0DE, 2'b10, 1'b1)));

    // R8: inbound error and readout error in one cycle
    do_reset();
    send_hdr(2'd1, 4'd1, 1'b0);
    send_beat(16'h0AAA, 2'b11, 1'b1);
    clear_all();
    send_hdr(2'd0, 4'd1, 1'b0);
    @(negedge clk);
    in_valid = 1; {in_par, in_be, in_data} = ent(16'h0BBB, 2'b11, 1'b1);
    agp_ready = 1;
    @(negedge clk);
    in_valid = 0; agp_ready = 0;
    chk("R8 both bits", 32'(err_status), 32'b001010);

    // R11: full queue stalls the link
    do_reset();
    send_hdr(2'd0, 4'd9, 1'b0);
    for (int i = 0; i < 8; i++) send_beat(16'h0100 + 16'(i), 2'b11, 1'b0);
    @(negedge clk);
    in_valid = 1; {in_par, in_be, in_data} = ent(16'h0108, 2'b11, 1'b0);
    #1;
    chk("R11 stall when full", 32'(in_ready), 32'd0);
    pciw_ready = 1;
    @(negedge clk);
    pciw_ready = 0;
    #1;
    chk("R11 ready after pop", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 0;
    for (int i = 1; i < 9; i++)
      pop_chk("R11 order", 0, ent(16'h0100 + 16'(i), 2'b11, 1'b0), 1'b0);
    chk("R11 drained", 32'(pciw_valid), 32'd0);

    // R12: high-priority AGP first
    do_reset();
    send_hdr(2'd1, 4'd1, 1'b0);
    send_beat(16'h1111, 2'b11, 1'b0);
    send_hdr(2'd2, 4'd1, 1'b0);
    send_beat(16'h2222, 2'b11, 1'b0);
    pop_chk("R12 high first", 1, ent(16'h2222, 2'b11, 1'b0), 1'b1);
    pop_chk("R12 low next", 1, ent(16'h1111, 2'b11, 1'b0), 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule